// File: doc/BRIEF.md
# Two-Pass 64-bit Memory Adder Controller

This block walks through a region of word-addressed memory, takes consecutive pairs of 64-bit unsigned operands, adds each pair and stores the sum in a separate output region. The memory it drives is two 32-bit banks behind a single address and control set. The low bank holds result bits 31:0 and the high bank holds bits 63:32, and each bank returns read data one cycle after the read is issued. The block joins the two bank outputs into one 64-bit read word and splits its 64-bit write word across them.

Only one 32-bit adder is present. Each pair is summed in two passes, the low halves first with a carry-in of zero and then the high halves with the registered carry of the first pass. The operand fetches overlap the memory latency, so one pair takes five cycles from its first read to its write. A start pulse loads a read pointer and a write pointer from base inputs. After every write the read pointer moves on by two and the write pointer by one. The run ends once the write pointer equals the end address, and `done` then holds until the next start.

Top module: `madd_ctrl`

## Requirements
- R1: While reset is asserted and while idle after reset, `done` is 0 and `mem_en` is 0.
- R2: A start pulse seen at a clock edge in the idle or finished state loads the read pointer from `rd_base` and the write pointer from `wr_base`, and the first read is driven in the cycle right after that edge.
- R3: Each pair is fetched by a read (`mem_en`=1, `mem_rw_n`=1) at the read pointer, and in the next cycle by a read at the read pointer plus 1.
- R4: The word written for a pair equals (A + B) mod 2^64, where A is at the lower address and B at the next one, and the carry out of bits 31:0 enters bit 32.
- R5: A carry out of bit 63 is dropped. For example, all-ones plus one writes zero.
- R6: Each pair takes five cycles: read A, read B, two cycles with `mem_en`=0, then one write cycle (`mem_en`=1, `mem_rw_n`=0) that carries the full 64-bit sum on `mem_wdata`.
- R7: Pair k (counting from 0) reads `rd_base`+2k and `rd_base`+2k+1 and writes `wr_base`+k. All addresses wrap modulo 2^AW.
- R8: The run stops after the write that moves the write pointer to `wr_end`, so it performs (`wr_end`-`wr_base`) mod 2^AW writes. `done` rises in the cycle after the last write and no memory access follows.
- R9: `done` stays high until a start pulse arrives. A start pulse in the finished state begins a new run as in R2.
- R10: A start pulse with `wr_base` equal to `wr_end` causes no memory access, and `done` is high in the next cycle.
- R11: A start pulse during a run has no effect on the addresses, data or timing of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle or finished |
| rd_base | input | AW | First operand address |
| wr_base | input | AW | First result address |
| wr_end | input | AW | Write address at which the run stops |
| done | output | 1 | High in the finished state |
| mem_en | output | 1 | Memory access enable shared by both banks |
| mem_rw_n | output | 1 | 1 = read, 0 = write |
| mem_addr | output | AW | Shared bank address |
| mem_wdata | output | 2*HW | Write word, high half to the high bank |
| mem_rdata | input | 2*HW | Joined read word from the two banks |

## Verification
Once a start pulse has been sampled, every port value in a run is fixed by the cycle index c counted from that edge. For pair k, the A read is in cycle 5k+1 and the B read in cycle 5k+2, cycles 5k+3 and 5k+4 are quiet, and the write with its sum is in cycle 5k+5. With N pairs, `done` is due in cycle 5N+1. The bench starts each run from a clock edge, counts cycles itself, and compares enable, direction, address, write data and `done` at the falling edge of every cycle against values derived from that index and from its own copy of memory. As a result, a transfer one cycle early or late fails as well as a wrong value.

// File: rtl/madd_pkg.sv
package madd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RDA  = 3'd1,
      ST_RDB  = 3'd2,
      ST_LO   = 3'd3,
      ST_HI   = 3'd4,
      ST_WR   = 3'd5,
      ST_END  = 3'd6
   } madd_state_e;

endpackage

// File: rtl/madd_half_add.sv
module madd_half_add #(
   parameter int W      = 32,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         ci,
   output logic [W-1:0] s,
   output logic         co
);

   if (W < 1) begin : g_bad_width
      $error("madd_half_add: W must be at least 1");
   end

   if (RIPPLE) begin : g_ripple
      logic [W:0] c;
      assign c[0] = ci;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign s[i]   = a[i] ^ b[i] ^ c[i];
         assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
      end
      assign co = c[W];
   end else begin : g_infer
      logic [W:0] wide;
      assign wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
      assign s    = wide[W-1:0];
      assign co   = wide[W];
   end

endmodule

// File: rtl/madd_seq.sv
module madd_seq
   import madd_pkg::*;
#(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] rd_base,
   input  logic [AW-1:0] wr_base,
   input  logic [AW-1:0] wr_end,
   output madd_state_e   state,
   output logic          done,
   output logic          mem_en,
   output logic          mem_rw_n,
   output logic [AW-1:0] mem_addr
);

   localparam logic [AW-1:0] ONE = AW'(1);
   localparam logic [AW-1:0] TWO = AW'(2);

   if (AW < 2) begin : g_bad_aw
      $error("madd_seq: AW must be at least 2");
   end

   madd_state_e   state_q;
   logic [AW-1:0] rd_ptr;
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] wr_next;

   assign wr_next = wr_ptr + ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rd_ptr  <= '0;
         wr_ptr  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE, ST_END: begin
               if (start) begin
                  rd_ptr  <= rd_base;
                  wr_ptr  <= wr_base;
                  state_q <= (wr_base == wr_end) ? ST_END : ST_RDA;
               end
            end
            ST_RDA: state_q <= ST_RDB;
            ST_RDB: state_q <= ST_LO;
            ST_LO:  state_q <= ST_HI;
            ST_HI:  state_q <= ST_WR;
            ST_WR: begin
               rd_ptr  <= rd_ptr + TWO;
               wr_ptr  <= wr_next;
               state_q <= (wr_next == wr_end) ? ST_END : ST_RDA;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_en   = 1'b0;
      mem_rw_n = 1'b1;
      mem_addr = rd_ptr;
      unique case (state_q)
         ST_RDA: mem_en = 1'b1;
         ST_RDB: begin
            mem_en   = 1'b1;
            mem_addr = rd_ptr + ONE;
         end
         ST_WR: begin
            mem_en   = 1'b1;
            mem_rw_n = 1'b0;
            mem_addr = wr_ptr;
         end
         default: ;
      endcase
   end

   assign state = state_q;
   assign done  = (state_q == ST_END);

   assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE || state_q == ST_END) |-> !mem_en);

   assert_pair_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RDA) |=> (mem_en && mem_rw_n && mem_addr == $past(mem_addr) + ONE));

   assert_write_stride_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WR) |=> (wr_ptr == $past(wr_ptr) + ONE && rd_ptr == $past(rd_ptr) + TWO));

   assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

endmodule

// File: rtl/madd_datapath.sv
module madd_datapath
   import madd_pkg::*;
#(
   parameter int HW     = 32,
   parameter bit RIPPLE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  madd_state_e     state,
   input  logic [2*HW-1:0] mem_rdata,
   output logic [2*HW-1:0] mem_wdata
);

   localparam int DW = 2 * HW;

   logic [DW-1:0] opa_q;
   logic [DW-1:0] opb_q;
   logic [HW-1:0] sum_lo_q;
   logic [HW-1:0] sum_hi_q;
   logic          carry_q;

   logic [HW-1:0] add_a;
   logic [HW-1:0] add_b;
   logic          add_ci;
   logic [HW-1:0] add_s;
   logic          add_co;

   always_comb begin
      add_a  = opa_q[HW-1:0];
      add_b  = mem_rdata[HW-1:0];
      add_ci = 1'b0;
      if (state == ST_HI) begin
         add_a  = opa_q[DW-1:HW];
         add_b  = opb_q[DW-1:HW];
         add_ci = carry_q;
      end
   end

   madd_half_add #(.W(HW), .RIPPLE(RIPPLE)) u_add (
      .a  (add_a),
      .b  (add_b),
      .ci (add_ci),
      .s  (add_s),
      .co (add_co)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opa_q    <= '0;
         opb_q    <= '0;
         sum_lo_q <= '0;
         sum_hi_q <= '0;
         carry_q  <= 1'b0;
      end else begin
         unique case (state)
            ST_RDB: opa_q <= mem_rdata;
            ST_LO: begin
               opb_q    <= mem_rdata;
               sum_lo_q <= add_s;
               carry_q  <= add_co;
            end
            ST_HI: sum_hi_q <= add_s;
            default: ;
         endcase
      end
   end

   assign mem_wdata = {sum_hi_q, sum_lo_q};

   logic [HW:0] ref_lo;
   assign ref_lo = {1'b0, opa_q[HW-1:0]} + {1'b0, opb_q[HW-1:0]};

   assert_carry_handoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HI) |-> (carry_q == ref_lo[HW] && sum_lo_q == ref_lo[HW-1:0]));

   assert_write_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WR) |-> (mem_wdata == opa_q + opb_q));

endmodule

// File: rtl/madd_ctrl.sv
module madd_ctrl #(
   parameter int AW     = 10,
   parameter int HW     = 32,
   parameter bit RIPPLE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [AW-1:0]   rd_base,
   input  logic [AW-1:0]   wr_base,
   input  logic [AW-1:0]   wr_end,
   output logic            done,
   output logic            mem_en,
   output logic            mem_rw_n,
   output logic [AW-1:0]   mem_addr,
   output logic [2*HW-1:0] mem_wdata,
   input  logic [2*HW-1:0] mem_rdata
);

   if (HW < 1) begin : g_bad_hw
      $error("madd_ctrl: HW must be at least 1");
   end

   madd_pkg::madd_state_e state;

   madd_seq #(.AW(AW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .rd_base  (rd_base),
      .wr_base  (wr_base),
      .wr_end   (wr_end),
      .state    (state),
      .done     (done),
      .mem_en   (mem_en),
      .mem_rw_n (mem_rw_n),
      .mem_addr (mem_addr)
   );

   madd_datapath #(.HW(HW), .RIPPLE(RIPPLE)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (state),
      .mem_rdata (mem_rdata),
      .mem_wdata (mem_wdata)
   );

   assert_no_access_in_reset_R1: assert property (@(posedge clk)
      !rst_n |-> (!mem_en && !done));

endmodule

// File: tb/test_madd_ctrl.sv
module test_madd_ctrl;

   localparam int AW    = 10;
   localparam int HW    = 32;
   localparam int DW    = 2 * HW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] rd_base = '0;
   logic [AW-1:0] wr_base = '0;
   logic [AW-1:0] wr_end = '0;
   logic          done;
   logic          mem_en;
   logic          mem_rw_n;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   logic [HW-1:0] bank_lo [DEPTH];
   logic [HW-1:0] bank_hi [DEPTH];

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   madd_ctrl #(.AW(AW), .HW(HW)) i_madd_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .rd_base   (rd_base),
      .wr_base   (wr_base),
      .wr_end    (wr_end),
      .done      (done),
      .mem_en    (mem_en),
      .mem_rw_n  (mem_rw_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_rw_n) mem_rdata <= {bank_hi[mem_addr], bank_lo[mem_addr]};
         else begin
            bank_lo[mem_addr] <= mem_wdata[HW-1:0];
            bank_hi[mem_addr] <= mem_wdata[DW-1:HW];
         end
      end
   end

   function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
      return {bank_hi[a], bank_lo[a]};
   endfunction

   function automatic logic [DW-1:0] pair_sum(input logic [AW-1:0] a);
      return word_at(a) + word_at(a + AW'(1));
   endfunction

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic put_word(input logic [AW-1:0] a, input logic [DW-1:0] v);
      bank_lo[a] = v[HW-1:0];
      bank_hi[a] = v[DW-1:HW];
   endtask

   // one run: start sampled at a clock edge, then cycle c = 1.. checked at falling edges
   task automatic run_job(input logic [AW-1:0] rd, input logic [AW-1:0] wr,
                          input logic [AW-1:0] e, input int glitch);
      logic [AW-1:0] span;
      int n;
      span = e - wr;
      n = int'(span);
      @(negedge clk);
      rd_base = rd; wr_base = wr; wr_end = e; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int c = 1; c <= 5 * n; c++) begin
         int p;
         int k;
         logic [AW-1:0] a;
         logic [AW-1:0] w;
         p = (c - 1) % 5;
         k = (c - 1) / 5;
         a = rd + AW'(2 * k);
         w = wr + AW'(k);
         if (c == glitch) begin
            start = 1'b1; rd_base = ~rd; wr_base = ~wr;   // R11 stray start
         end else begin
            start = 1'b0;
         end
         chk(done == 1'b0, "R8 done low mid-run", DW'(done), '0);
         case (p)
            0: chk(mem_en && mem_rw_n && mem_addr == a, "R2 R3 R7 read A",
                   DW'({mem_en, mem_rw_n, mem_addr}), DW'({2'b11, a}));
            1: chk(mem_en && mem_rw_n && mem_addr == a + AW'(1), "R3 R7 read B",
                   DW'({mem_en, mem_rw_n, mem_addr}), DW'({2'b11, a + AW'(1)}));
            2, 3: chk(!mem_en, "R6 quiet cycle", DW'(mem_en), '0);
            default: begin
               chk(mem_en && !mem_rw_n && mem_addr == w, "R6 R7 write slot",
                   DW'({mem_en, mem_rw_n, mem_addr}), DW'({2'b10, w}));
               chk(mem_wdata == pair_sum(a), "R4 R5 sum", mem_wdata, pair_sum(a));
            end
         endcase
         @(negedge clk);
      end
      start = 1'b0;
      chk(done == 1'b1, "R8 R10 done after last write", DW'(done), DW'(1));
      chk(!mem_en, "R8 no access after end", DW'(mem_en), '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20260211));
      for (int i = 0; i < DEPTH; i++) put_word(AW'(i), {$urandom, $urandom});

      // R4: carry from bit 31 into bit 32
      put_word(AW'(0), 64'h0000_0001_FFFF_FFFF);
      put_word(AW'(1), 64'h0000_0000_0000_0001);
      // R5: carry out of bit 63 dropped
      put_word(AW'(2), 64'hFFFF_FFFF_FFFF_FFFF);
      put_word(AW'(3), 64'h0000_0000_0000_0001);
      // high-half only carry chain
      put_word(AW'(4), 64'h8000_0000_0000_0000);
      put_word(AW'(5), 64'h8000_0000_7FFF_FFFF);

      repeat (3) begin
         @(negedge clk);
         chk(!done && !mem_en, "R1 reset state", DW'({done, mem_en}), '0);
      end
      rst_n = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk(!done && !mem_en, "R1 idle after reset", DW'({done, mem_en}), '0);
      end

      run_job(AW'(0), AW'(512), AW'(515), 0);
      chk(word_at(AW'(512)) == 64'h0000_0002_0000_0000, "R4 carry across half",
          word_at(AW'(512)), 64'h0000_0002_0000_0000);
      chk(word_at(AW'(513)) == 64'h0, "R5 top carry dropped", word_at(AW'(513)), 64'h0);
      chk(word_at(AW'(514)) == 64'h0000_0000_7FFF_FFFF, "R5 high overflow",
          word_at(AW'(514)), 64'h0000_0000_7FFF_FFFF);

      // R9: done held without start
      repeat (8) begin
         @(negedge clk);
         chk(done && !mem_en, "R9 done holds", DW'({done, mem_en}), DW'(2'b10));
      end

      run_job(AW'(40), AW'(600), AW'(600), 0);              // R10 empty run
      run_job(AW'(16), AW'(700), AW'(712), 7);              // R11 stray start
      run_job(AW'(1020), AW'(1022), AW'(2), 0);             // R7 pointer wrap
      run_job(AW'(300), AW'(900), AW'(901), 0);             // single pair

      for (int j = 0; j < 4; j++) begin
         logic [AW-1:0] rd;
         logic [AW-1:0] wr;
         rd = AW'(100 + 2 * ($urandom % 80));
         wr = AW'(800 + 10 * j);
         run_job(rd, wr, wr + AW'(1 + $urandom % 6), int'($urandom % 12));
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule